// File: doc/BRIEF.md
# Splittable Dual 32-bit Timer

This block is a register-mapped timer built from two 32-bit up-counters, a lower half and an upper half. A global control register selects whether the halves are joined into one 64-bit counter or run as two independent 32-bit timers. It also holds one reset-release bit per half. A timer control register holds a 2-bit run mode for each half: off, one-shot or continuous. Each half also has a period register.

When an enabled count reaches its period, the block raises an interrupt pulse. In continuous mode the count then restarts from zero. In one-shot mode the count stops and the run mode clears itself. Software can load a counter register at any time and can read the live count back. With a period of all ones, a half becomes a free-running 32-bit counter.

Access uses a simple bus with address, write data, a write strobe and a read strobe. Read data is combinational and follows the current address while the read strobe is high.

Top module: `split_timer`

## Requirements
- R1: After a synchronous reset, every register reads 0 and both interrupt outputs are low.
- R2: The registers sit at these byte addresses: lower count 0x10, upper count 0x14, lower period 0x18, upper period 0x1C, timer control 0x20, global control 0x24. In timer control, the lower run mode is bits [7:6] and the upper run mode is bits [23:22]. In global control, bit 0 releases the lower half, bit 1 releases the upper half, and bits [3:2] hold the timer mode. Unused bits read 0. Unmapped addresses read 0. `bus_rdata` is 0 while `bus_rd` is low.
- R3: While a half's release bit is 0, its count is 0 one cycle later. It ignores counter writes and raises no interrupt.
- R4: Run mode 0 (off) freezes the count at its present value without clearing it. Run mode 3 behaves the same as off.
- R5: In split operation, an enabled and released half whose count differs from its period increments by 1 on each clock. It wraps from 2^32-1 to 0.
- R6: In continuous mode (run mode 2), a clock edge that sees count equal to period sets the count to 0. The half's interrupt is then high for the following cycle. A period of P gives one pulse every P+1 cycles.
- R7: In one-shot mode (run mode 1), a match raises one interrupt pulse. The count stays at the period value and the half's run-mode field reads back as 0.
- R8: A period of 0xFFFFFFFF with continuous mode counts freely. The count goes from 0xFFFFFFFF to 0 with an interrupt pulse.
- R9: A write to a counter register sets that count to the written value on the next cycle. It overrides counting, and no match is taken in that cycle.
- R10: If timer control is written in the same cycle as a one-shot completion, the written run mode is kept instead of the self-clear.
- R11: Timer mode 0 joins the halves into one 64-bit counter. A wrap of the lower count carries into the upper count. The match compares all 64 bits, and the lower run mode and `irq_lo` are used. The joined counter advances only when both halves are released, and `irq_hi` stays low. Timer modes 1, 2 and 3 give split operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, gates read data |
| bus_rdata | output | 32 | Combinational read data |
| irq_lo | output | 1 | Lower-half (or 64-bit) match pulse |
| irq_hi | output | 1 | Upper-half match pulse |

## Verification
Two functions can fall in the same cycle here. The first is a period match and a software load of the same counter. The bench provokes this by watching its reference model and writing the counter exactly on the cycle whose edge would otherwise match. It expects the loaded value and no pulse. The second is a one-shot self-clear and a control write. The bench provokes this by rewriting timer control on the completing edge while reading it back in the same cycle. It expects the written mode to survive and a second pulse to follow.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int NUM_HALF = 2;

    typedef enum logic [1:0] {
        RUN_OFF  = 2'd0,
        RUN_ONCE = 2'd1,
        RUN_LOOP = 2'd2,
        RUN_RSVD = 2'd3
    } run_mode_e;

    typedef enum logic [1:0] {
        GM_WIDE  = 2'd0,
        GM_SPLIT = 2'd1,
        GM_WDOG  = 2'd2,
        GM_CHAIN = 2'd3
    } glb_mode_e;

    // byte offsets
    localparam int OFS_CNT_LO = 'h10;
    localparam int OFS_PER_LO = 'h18;
    localparam int OFS_CTRL   = 'h20;
    localparam int OFS_GLB    = 'h24;
    localparam int HALF_STEP  = 4;

    // field positions
    localparam int RUN_LO_POS = 6;
    localparam int RUN_HI_POS = 22;
    localparam int GM_POS     = 2;
    localparam int REL_POS    = 0;

    function automatic logic run_active(input logic [1:0] m);
        return (m == RUN_ONCE) || (m == RUN_LOOP);
    endfunction

    function automatic int run_pos(input int h);
        return (h == 0) ? RUN_LO_POS : RUN_HI_POS;
    endfunction

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold_i,
    input  logic          load_i,
    input  logic [DW-1:0] load_val_i,
    input  logic          step_i,
    input  logic          restart_i,
    output logic [DW-1:0] cnt_o
);

    logic [DW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || hold_i)  cnt_q <= '0;
        else if (load_i)    cnt_q <= load_val_i;
        else if (restart_i) cnt_q <= '0;
        else if (step_i)    cnt_q <= cnt_q + DW'(1);
    end

    assign cnt_o = cnt_q;

    AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        hold_i |=> (cnt_o == '0)); // R3

    AST_STEP_ADDS: assert property (@(posedge clk) disable iff (rst)
        (step_i && !hold_i && !load_i && !restart_i) |=> (cnt_o == $past(cnt_o) + DW'(1))); // R5

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        (load_i && !hold_i) |=> (cnt_o == $past(load_val_i))); // R9

endmodule

// File: rtl/tmr_seq.sv
module tmr_seq
    import tmr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [1:0]                   mode_i,
    input  logic [NUM_HALF-1:0]          rel_i,
    input  logic [NUM_HALF-1:0][1:0]     run_i,
    input  logic [NUM_HALF-1:0][DW-1:0]  cnt_i,
    input  logic [NUM_HALF-1:0][DW-1:0]  per_i,
    input  logic [NUM_HALF-1:0]          ld_i,
    output logic [NUM_HALF-1:0]          step_o,
    output logic [NUM_HALF-1:0]          restart_o,
    output logic [NUM_HALF-1:0]          done_o
);

    logic              wide;
    logic              wide_act;
    logic              wide_hit;
    logic [NUM_HALF-1:0] act;
    logic [NUM_HALF-1:0] hit;

    assign wide = (mode_i == GM_WIDE);

    always_comb begin
        wide_act = (&rel_i) && !(|ld_i) && run_active(run_i[0]);
        wide_hit = wide_act && ({cnt_i[1], cnt_i[0]} == {per_i[1], per_i[0]});
        for (int h = 0; h < NUM_HALF; h++) begin
            act[h] = rel_i[h] && !ld_i[h] && run_active(run_i[h]);
            hit[h] = act[h] && (cnt_i[h] == per_i[h]);
        end
    end

    always_comb begin
        step_o    = '0;
        restart_o = '0;
        done_o    = '0;
        if (wide) begin
            done_o[0]    = wide_hit;
            restart_o    = {NUM_HALF{wide_hit && (run_i[0] == RUN_LOOP)}};
            step_o[0]    = wide_act && !wide_hit;
            step_o[1]    = wide_act && !wide_hit && (&cnt_i[0]);
        end else begin
            for (int h = 0; h < NUM_HALF; h++) begin
                done_o[h]    = hit[h];
                restart_o[h] = hit[h] && (run_i[h] == RUN_LOOP);
                step_o[h]    = act[h] && !hit[h];
            end
        end
    end

    AST_WIDE_NO_HI_DONE: assert property (@(posedge clk) disable iff (rst)
        (mode_i == GM_WIDE) |-> !done_o[1]); // R11

    AST_LO_DONE_AT_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (done_o[0] && mode_i != GM_WIDE) |-> (cnt_i[0] == per_i[0])); // R6

    AST_LOAD_BLOCKS_LO: assert property (@(posedge clk) disable iff (rst)
        ld_i[0] |-> (!step_o[0] && !done_o[0])); // R9

    AST_LOAD_BLOCKS_HI: assert property (@(posedge clk) disable iff (rst)
        ld_i[1] |-> (!step_o[1] && !done_o[1])); // R9

    AST_DONE_NEEDS_REL: assert property (@(posedge clk) disable iff (rst)
        done_o[1] |-> rel_i[1]); // R3

endmodule

// File: rtl/tmr_regfile.sv
module tmr_regfile
    import tmr_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [AW-1:0]                addr_i,
    input  logic [DW-1:0]                wdata_i,
    input  logic                         wr_i,
    input  logic                         rd_i,
    input  logic [NUM_HALF-1:0][DW-1:0]  cnt_i,
    input  logic [NUM_HALF-1:0]          done_i,
    output logic [NUM_HALF-1:0]          ld_o,
    output logic [NUM_HALF-1:0][DW-1:0]  per_o,
    output logic [NUM_HALF-1:0][1:0]     run_o,
    output logic [1:0]                   mode_o,
    output logic [NUM_HALF-1:0]          rel_o,
    output logic [DW-1:0]                rdata_o
);

    localparam logic [AW-1:0] A_CTRL = AW'(OFS_CTRL);
    localparam logic [AW-1:0] A_GLB  = AW'(OFS_GLB);

    logic                        ctrl_wr;
    logic                        glb_wr;
    logic [NUM_HALF-1:0][DW-1:0] per_q;
    logic [NUM_HALF-1:0][1:0]    run_q;
    logic [1:0]                  mode_q;
    logic [NUM_HALF-1:0]         rel_q;
    logic [DW-1:0]               ctrl_img;
    logic [DW-1:0]               glb_img;

    assign ctrl_wr = wr_i && (addr_i == A_CTRL);
    assign glb_wr  = wr_i && (addr_i == A_GLB);

    for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
        localparam int            EP    = run_pos(h);
        localparam logic [AW-1:0] A_CNT = AW'(OFS_CNT_LO + HALF_STEP * h);
        localparam logic [AW-1:0] A_PER = AW'(OFS_PER_LO + HALF_STEP * h);

        assign ld_o[h] = wr_i && (addr_i == A_CNT);

        always_ff @(posedge clk) begin
            if (rst) begin
                per_q[h] <= '0;
                run_q[h] <= RUN_OFF;
            end else begin
                if (wr_i && (addr_i == A_PER))
                    per_q[h] <= wdata_i;
                if (ctrl_wr)
                    run_q[h] <= wdata_i[EP +: 2];
                else if (done_i[h] && (run_q[h] == RUN_ONCE))
                    run_q[h] <= RUN_OFF;
            end
        end

        AST_ONCE_RETIRES: assert property (@(posedge clk) disable iff (rst)
            (done_i[h] && (run_q[h] == RUN_ONCE) && !ctrl_wr) |=> (run_q[h] == RUN_OFF)); // R7

        AST_CTRL_WINS: assert property (@(posedge clk) disable iff (rst)
            ctrl_wr |=> (run_q[h] == $past(wdata_i[EP +: 2]))); // R10
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= GM_WIDE;
            rel_q  <= '0;
        end else if (glb_wr) begin
            mode_q <= wdata_i[GM_POS +: 2];
            rel_q  <= wdata_i[REL_POS +: NUM_HALF];
        end
    end

    always_comb begin
        ctrl_img = '0;
        ctrl_img[RUN_LO_POS +: 2] = run_q[0];
        ctrl_img[RUN_HI_POS +: 2] = run_q[1];
        glb_img = '0;
        glb_img[GM_POS +: 2]         = mode_q;
        glb_img[REL_POS +: NUM_HALF] = rel_q;
    end

    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            case (addr_i)
                AW'(OFS_CNT_LO):             rdata_o = cnt_i[0];
                AW'(OFS_CNT_LO + HALF_STEP): rdata_o = cnt_i[1];
                AW'(OFS_PER_LO):             rdata_o = per_q[0];
                AW'(OFS_PER_LO + HALF_STEP): rdata_o = per_q[1];
                A_CTRL:                      rdata_o = ctrl_img;
                A_GLB:                       rdata_o = glb_img;
                default:                     rdata_o = '0;
            endcase
        end
    end

    assign per_o  = per_q;
    assign run_o  = run_q;
    assign mode_o = mode_q;
    assign rel_o  = rel_q;

    AST_GLB_TAKES: assert property (@(posedge clk) disable iff (rst)
        glb_wr |=> (rel_o == $past(wdata_i[REL_POS +: NUM_HALF]))); // R2

endmodule

// File: rtl/split_timer.sv
module split_timer
    import tmr_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_wr,
    input  logic          bus_rd,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_lo,
    output logic          irq_hi
);

    logic [NUM_HALF-1:0][DW-1:0] cnt;
    logic [NUM_HALF-1:0][DW-1:0] per;
    logic [NUM_HALF-1:0][1:0]    run;
    logic [NUM_HALF-1:0]         rel;
    logic [NUM_HALF-1:0]         ld;
    logic [NUM_HALF-1:0]         step;
    logic [NUM_HALF-1:0]         restart;
    logic [NUM_HALF-1:0]         done;
    logic [1:0]                  mode;
    logic [NUM_HALF-1:0]         irq_q;

    tmr_regfile #(.AW(AW), .DW(DW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .wr_i    (bus_wr),
        .rd_i    (bus_rd),
        .cnt_i   (cnt),
        .done_i  (done),
        .ld_o    (ld),
        .per_o   (per),
        .run_o   (run),
        .mode_o  (mode),
        .rel_o   (rel),
        .rdata_o (bus_rdata)
    );

    tmr_seq #(.DW(DW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .mode_i    (mode),
        .rel_i     (rel),
        .run_i     (run),
        .cnt_i     (cnt),
        .per_i     (per),
        .ld_i      (ld),
        .step_o    (step),
        .restart_o (restart),
        .done_o    (done)
    );

    for (genvar h = 0; h < NUM_HALF; h++) begin : g_cnt
        tmr_counter #(.DW(DW)) u_cnt (
            .clk        (clk),
            .rst        (rst),
            .hold_i     (!rel[h]),
            .load_i     (ld[h]),
            .load_val_i (bus_wdata),
            .step_i     (step[h]),
            .restart_i  (restart[h]),
            .cnt_o      (cnt[h])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= '0;
        else     irq_q <= done;
    end

    assign irq_lo = irq_q[0];
    assign irq_hi = irq_q[1];

    AST_WIDE_QUIET_HI: assert property (@(posedge clk) disable iff (rst)
        irq_hi |-> ($past(mode) != GM_WIDE)); // R11

    AST_IRQ_NEEDS_REL: assert property (@(posedge clk) disable iff (rst)
        irq_lo |-> $past(rel[0])); // R3

    AST_LOOP_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        (irq_lo && $past(mode) != GM_WIDE && $past(run[0]) == RUN_LOOP && $past(rel[0]))
        |-> (cnt[0] == '0)); // R6

endmodule

// File: tb/sim_split_timer.sv
module sim_split_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq_lo;
    logic        irq_hi;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    split_timer u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .irq_lo    (irq_lo),
        .irq_hi    (irq_hi)
    );

    // reference model state
    logic [31:0] m_cnt [2];
    logic [31:0] m_per [2];
    logic [1:0]  m_run [2];
    logic [1:0]  m_mode;
    logic [1:0]  m_rel;
    logic        m_irq [2];

    function automatic logic [31:0] model_read(input logic r, input logic [7:0] a);
        if (!r) return 32'h0;
        case (a)
            8'h10: return m_cnt[0];
            8'h14: return m_cnt[1];
            8'h18: return m_per[0];
            8'h1C: return m_per[1];
            8'h20: return (32'(m_run[1]) << 22) | (32'(m_run[0]) << 6);
            8'h24: return {28'h0, m_mode, m_rel};
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_step();
        logic [31:0] nc [2];
        logic [1:0]  nr [2];
        logic        ni [2];
        logic        cw [2];
        logic [63:0] full;
        if (rst) begin
            for (int h = 0; h < 2; h++) begin
                m_cnt[h] = 0; m_per[h] = 0; m_run[h] = 0; m_irq[h] = 0;
            end
            m_mode = 0; m_rel = 0;
            return;
        end
        cw[0] = bus_wr && bus_addr == 8'h10;
        cw[1] = bus_wr && bus_addr == 8'h14;
        for (int h = 0; h < 2; h++) begin
            nc[h] = m_cnt[h]; nr[h] = m_run[h]; ni[h] = 1'b0;
        end
        if (m_mode == 2'd0) begin
            if (m_rel == 2'b11 && !cw[0] && !cw[1] && (m_run[0] == 1 || m_run[0] == 2)) begin
                full = {m_cnt[1], m_cnt[0]};
                if (full == {m_per[1], m_per[0]}) begin
                    ni[0] = 1'b1;
                    if (m_run[0] == 2) full = 0; else nr[0] = 0;
                end else begin
                    full = full + 64'd1;
                end
                nc[0] = full[31:0]; nc[1] = full[63:32];
            end
        end else begin
            for (int h = 0; h < 2; h++) begin
                if (m_rel[h] && !cw[h] && (m_run[h] == 1 || m_run[h] == 2)) begin
                    if (m_cnt[h] == m_per[h]) begin
                        ni[h] = 1'b1;
                        if (m_run[h] == 2) nc[h] = 0; else nr[h] = 0;
                    end else begin
                        nc[h] = m_cnt[h] + 1;
                    end
                end
            end
        end
        for (int h = 0; h < 2; h++) begin
            if (cw[h]) nc[h] = bus_wdata;
            if (!m_rel[h]) nc[h] = 0;
        end
        if (bus_wr && bus_addr == 8'h20) begin
            nr[0] = bus_wdata[7:6]; nr[1] = bus_wdata[23:22];
        end
        if (bus_wr && bus_addr == 8'h18) m_per[0] = bus_wdata;
        if (bus_wr && bus_addr == 8'h1C) m_per[1] = bus_wdata;
        if (bus_wr && bus_addr == 8'h24) begin
            m_mode = bus_wdata[3:2]; m_rel = bus_wdata[1:0];
        end
        for (int h = 0; h < 2; h++) begin
            m_cnt[h] = nc[h]; m_run[h] = nr[h]; m_irq[h] = ni[h];
        end
    endtask

    always @(posedge clk) model_step();

    task automatic expect32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare();
        expect32({cur_req, " irq_lo"}, 32'(irq_lo), 32'(m_irq[0]));
        expect32({cur_req, " irq_hi"}, 32'(irq_hi), 32'(m_irq[1]));
        expect32({cur_req, " rdata"}, bus_rdata, model_read(bus_rd, bus_addr));
    endtask

    task automatic cyc(input logic w, input logic r, input logic [7:0] a, input logic [31:0] d);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cyc(1'b1, 1'b0, a, d);
    endtask

    task automatic idle(input int n, input logic [7:0] a);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b1, a, 32'h0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int pulses;
        logic [31:0] v1;
        // R1: reset
        cur_req = "R1";
        cyc(1'b0, 1'b0, 8'h0, 32'h0);
        cyc(1'b0, 1'b0, 8'h0, 32'h0);
        rst = 1'b0;
        for (int a = 'h10; a <= 'h24; a += 4) begin
            cyc(1'b0, 1'b1, 8'(a), 32'h0);
            expect32("R1 reset read", bus_rdata, 32'h0);
        end

        // R2: field placement and unused bits
        cur_req = "R2";
        wr(8'h20, 32'hFFFF_FFFF);
        cyc(1'b0, 1'b1, 8'h20, 32'h0);
        expect32("R2 ctrl fields", bus_rdata, 32'h00C0_00C0);
        wr(8'h24, 32'hFFFF_FFF6);
        cyc(1'b0, 1'b1, 8'h24, 32'h0);
        expect32("R2 glb fields", bus_rdata, 32'h0000_0006);
        cyc(1'b0, 1'b1, 8'h04, 32'h0);
        expect32("R2 unmapped", bus_rdata, 32'h0);
        wr(8'h20, 32'h0);

        // R5 R6: split continuous on lower half
        cur_req = "R6";
        wr(8'h24, 32'h0000_0007);
        wr(8'h10, 32'h0);
        wr(8'h18, 32'd5);
        wr(8'h20, 32'h2 << 6);
        pulses = 0;
        for (int i = 0; i < 18; i++) begin
            cyc(1'b0, 1'b1, 8'h10, 32'h0);
            if (irq_lo) pulses++;
            if (i == 2) expect32("R5 count step", bus_rdata, 32'd3);
        end
        expect32("R6 pulse count", 32'(pulses), 32'd3);

        // R4: freeze with off and reserved mode
        cur_req = "R4";
        idle(2, 8'h10);
        wr(8'h20, 32'h0);
        cyc(1'b0, 1'b1, 8'h10, 32'h0);
        v1 = bus_rdata;
        idle(3, 8'h10);
        expect32("R4 frozen off", bus_rdata, v1);
        wr(8'h20, 32'h3 << 6);
        idle(3, 8'h10);
        expect32("R4 frozen mode3", bus_rdata, v1);
        wr(8'h20, 32'h0);

        // R7: one-shot on upper half
        cur_req = "R7";
        wr(8'h14, 32'h0);
        wr(8'h1C, 32'd3);
        wr(8'h20, 32'h1 << 22);
        pulses = 0;
        for (int i = 0; i < 8; i++) begin
            cyc(1'b0, 1'b1, 8'h14, 32'h0);
            if (irq_hi) pulses++;
        end
        expect32("R7 single pulse", 32'(pulses), 32'd1);
        expect32("R7 count held", bus_rdata, 32'd3);
        cyc(1'b0, 1'b1, 8'h20, 32'h0);
        expect32("R7 mode cleared", bus_rdata, 32'h0);

        // R9: counter write on the match edge
        cur_req = "R9";
        wr(8'h10, 32'h0);
        wr(8'h18, 32'd6);
        wr(8'h20, 32'h2 << 6);
        for (int i = 0; i < 20 && m_cnt[0] != m_per[0]; i++) idle(1, 8'h10);
        cyc(1'b1, 1'b1, 8'h10, 32'd2);
        expect32("R9 no pulse on load", 32'(irq_lo), 32'd0);
        expect32("R9 loaded value", bus_rdata, 32'd2);
        idle(6, 8'h10);
        wr(8'h20, 32'h0);

        // R10: ctrl write collides with one-shot completion
        cur_req = "R10";
        wr(8'h14, 32'h0);
        wr(8'h1C, 32'd2);
        wr(8'h20, 32'h1 << 22);
        for (int i = 0; i < 20 && m_cnt[1] != m_per[1]; i++) idle(1, 8'h14);
        cyc(1'b1, 1'b1, 8'h20, 32'h1 << 22);
        expect32("R10 written mode kept", bus_rdata, 32'h1 << 22);
        expect32("R10 first pulse", 32'(irq_hi), 32'd1);
        cyc(1'b0, 1'b1, 8'h20, 32'h0);
        expect32("R10 second pulse", 32'(irq_hi), 32'd1);
        idle(3, 8'h14);

        // R8: free-running wrap
        cur_req = "R8";
        wr(8'h20, 32'h0);
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h10, 32'hFFFF_FFFD);
        wr(8'h20, 32'h2 << 6);
        idle(3, 8'h10);
        expect32("R8 wrapped count", bus_rdata, 32'h0);
        expect32("R8 wrap pulse", 32'(irq_lo), 32'd1);
        idle(4, 8'h10);
        expect32("R8 counting on", bus_rdata, 32'd4);

        // R3: held half
        cur_req = "R3";
        wr(8'h20, 32'h0);
        wr(8'h24, 32'h0000_0005);
        wr(8'h14, 32'h55);
        cyc(1'b0, 1'b1, 8'h14, 32'h0);
        expect32("R3 held count", bus_rdata, 32'h0);
        wr(8'h20, (32'h2 << 22) | (32'h2 << 6));
        idle(4, 8'h14);
        expect32("R3 no counting", bus_rdata, 32'h0);

        // R11: joined 64-bit mode
        cur_req = "R11";
        wr(8'h20, 32'h0);
        wr(8'h24, 32'h0000_0003);
        wr(8'h10, 32'hFFFF_FFFE);
        wr(8'h14, 32'h0);
        wr(8'h18, 32'd2);
        wr(8'h1C, 32'd1);
        wr(8'h20, (32'h2 << 22) | (32'h2 << 6));
        idle(2, 8'h14);
        expect32("R11 carry into upper", bus_rdata, 32'd1);
        pulses = 0;
        for (int i = 0; i < 6; i++) begin
            cyc(1'b0, 1'b1, 8'h10, 32'h0);
            if (irq_lo) pulses++;
            if (irq_hi) pulses += 100;
        end
        expect32("R11 one wide pulse", 32'(pulses), 32'd1);

        finish_run();
    end

endmodule